// File: doc/BRIEF.md
# Video Memory Copy Engine

This block moves data from anywhere in the system address space into video memory on behalf of the CPU. Software loads a 16-bit source and a 16-bit destination into four byte registers, then writes a control byte. That write either launches one bulk copy of the whole requested length or arms a paced mode. In paced mode the block moves one 16-byte slice each time the display enters horizontal blanking. A copy is carried out as byte reads and writes on a plain memory port, and the CPU is held off while bytes are moving.

The control byte reads back as progress. After a bulk copy it reads 0xFF. In paced mode it holds the number of slices still to go minus one, counting down after each slice. When it wraps to 0xFF, paced mode ends. The four address registers are updated at the end of every burst, so a later burst carries on where the previous one stopped.

Top module: `vram_copy_dma`

## Requirements
- R1: After reset the four address registers read 0x00, the control register reads 0xFF, `cpu_stall` is low and no memory write occurs.
- R2: Register select codes are 0 source high, 1 source low, 2 destination high, 3 destination low and 4 control. The copy source is the source pair with its low four bits cleared. The copy destination is 0x8000 ORed with the destination pair masked to 0x1FF0. Both addresses advance by one per byte as 16-bit counters.
- R3: A control write whose masked source lies in 0x8000..0x9FFF starts nothing and leaves paced mode unchanged. The control register then reads the written value with bit 7 set.
- R4: A control write with bit 7 clear starts a bulk copy when paced mode is not armed. It copies (bits 6:0 + 1) x 16 bytes. One byte moves every BYTE_GAP cycles, and each written byte equals the byte read in the same cycle.
- R5: `cpu_stall` rises in the cycle of the first byte of a burst, stays high through the last byte and falls in the following cycle.
- R6: When a burst ends, the address registers read the source and destination one past the last byte moved. After a bulk copy the control register reads 0xFF.
- R7: A control write with bit 7 set, while the LCD is on and the video mode is 0, starts one 16-byte slice at once. The control register reads bits 6:0 of the written value, minus one once the slice ends.
- R8: A control write with bit 7 set, while the LCD is on and the video mode is not 0, arms paced mode without copying, and the control register reads bits 6:0. Each `hblank_pulse` then moves exactly one 16-byte slice and decrements the control register. When that register wraps to 0xFF, paced mode ends and later pulses move nothing.
- R9: A control write with bit 7 set while the LCD is off moves nothing, and the control register reads 0x80 | ((value + 1) & 0x7F). Pulses are ignored while the LCD is off. After the LCD is turned on, a pulse moves a slice.
- R10: While a burst runs, register writes and `hblank_pulse` are ignored. Pulses are also ignored when paced mode is not armed.
- R11: A control write with bit 7 clear while paced mode is armed, and the LCD is not on in video mode 0, cancels paced mode and moves nothing. The control register then reads bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for writes |
| reg_wdata | input | 8 | Register write data |
| reg_rd_sel | input | 3 | Register select for readback |
| reg_rdata | output | 8 | Readback value of the selected register |
| lcd_on | input | 1 | Display enabled |
| vid_mode | input | 2 | Current video mode |
| hblank_pulse | input | 1 | One-cycle pulse on horizontal blank entry |
| mem_rd | output | 1 | Byte read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle |
| mem_wr | output | 1 | Byte write request |
| mem_wr_addr | output | 16 | Write address |
| mem_wdata | output | 8 | Write data |
| cpu_stall | output | 1 | CPU held off while a burst runs |

## Verification
The bench builds the block with BYTE_GAP set to 2, which halves the byte pacing. This keeps the longest bulk copy, 128 blocks or 2048 bytes, short enough to run in full. That copy carries the destination past 0x9FFF and the source across a high-byte boundary. A scoreboard predicts every address and data byte of each burst. It also checks the spacing between writes, so both the pacing counter and the per-byte address stepping are exercised at a non-default gap.

// File: rtl/vram_copy_dma.sv
module vram_copy_dma #(
  parameter int BYTE_GAP    = 4,
  parameter int BLOCK_BYTES = 16,
  parameter int LEN_BITS    = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic [2:0]  reg_rd_sel,
  output logic [7:0]  reg_rdata,
  input  logic        lcd_on,
  input  logic [1:0]  vid_mode,
  input  logic        hblank_pulse,
  output logic        mem_rd,
  output logic [15:0] mem_rd_addr,
  input  logic [7:0]  mem_rdata,
  output logic        mem_wr,
  output logic [15:0] mem_wr_addr,
  output logic [7:0]  mem_wdata,
  output logic        cpu_stall
);
  localparam int CNT_W  = $clog2((1 << LEN_BITS) * BLOCK_BYTES) + 1;
  localparam int SLOT_W = (BYTE_GAP > 1) ? $clog2(BYTE_GAP) : 1;

  logic [7:0]        src_hi, src_lo, dst_hi, dst_lo, ctl;
  logic              hb_mode, busy;
  logic [15:0]       cur_src, cur_dst;
  logic [CNT_W-1:0]  left;
  logic [SLOT_W-1:0] slot;

  wire [15:0] src_w  = {src_hi, src_lo} & 16'hFFF0;
  wire [15:0] dst_w  = ({dst_hi, dst_lo} & 16'h1FF0) | 16'h8000;
  wire        ctl_wr = reg_wr && !busy && reg_sel == 3'd4;
  wire        src_bad = src_w[15:13] == 3'b100;
  wire        new_hb = reg_wdata[7];
  wire        go_now = (!hb_mode && !new_hb) || (lcd_on && vid_mode == 2'd0);
  wire        hb_go  = hblank_pulse && hb_mode && lcd_on && !busy && !ctl_wr;
  wire        step   = busy && slot == '0;
  wire        last   = step && left == CNT_W'(1);
  wire [7:0]  ctl_dec = ctl - 8'd1;
  wire [15:0] nxt_src = cur_src + 16'd1;
  wire [15:0] nxt_dst = cur_dst + 16'd1;
  wire [CNT_W-1:0] gen_len =
    (CNT_W'(reg_wdata[LEN_BITS-1:0]) + CNT_W'(1)) * CNT_W'(BLOCK_BYTES);

  assign mem_rd      = step;
  assign mem_wr      = step;
  assign mem_rd_addr = cur_src;
  assign mem_wr_addr = cur_dst;
  assign mem_wdata   = mem_rdata;
  assign cpu_stall   = busy;

  always_comb begin
    case (reg_rd_sel)
      3'd0:    reg_rdata = src_hi;
      3'd1:    reg_rdata = src_lo;
      3'd2:    reg_rdata = dst_hi;
      3'd3:    reg_rdata = dst_lo;
      3'd4:    reg_rdata = ctl;
      default: reg_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi <= 8'h00; src_lo <= 8'h00;
      dst_hi <= 8'h00; dst_lo <= 8'h00;
      ctl <= 8'hFF; hb_mode <= 1'b0; busy <= 1'b0;
      cur_src <= '0; cur_dst <= '0; left <= '0; slot <= '0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_sel)
          3'd0: src_hi <= reg_wdata;
          3'd1: src_lo <= reg_wdata;
          3'd2: dst_hi <= reg_wdata;
          3'd3: dst_lo <= reg_wdata;
          default: ;
        endcase
      end
      if (ctl_wr) begin
        if (src_bad) begin
          ctl <= reg_wdata | 8'h80;
        end else begin
          cur_src <= src_w;
          cur_dst <= dst_w;
          hb_mode <= new_hb;
          if (go_now) begin
            busy <= 1'b1;
            slot <= '0;
            left <= new_hb ? CNT_W'(BLOCK_BYTES) : gen_len;
            ctl  <= reg_wdata & 8'h7F;
          end else if (new_hb && !lcd_on) begin
            ctl <= 8'h80 | ((reg_wdata + 8'd1) & 8'h7F);
          end else begin
            ctl <= reg_wdata & 8'h7F;
          end
        end
      end
      if (hb_go) begin
        busy <= 1'b1;
        slot <= '0;
        left <= CNT_W'(BLOCK_BYTES);
      end
      if (busy) begin
        slot <= (slot == SLOT_W'(BYTE_GAP - 1)) ? '0 : slot + SLOT_W'(1);
        if (step) begin
          cur_src <= nxt_src;
          cur_dst <= nxt_dst;
          left    <= left - CNT_W'(1);
        end
        if (last) begin
          busy   <= 1'b0;
          src_hi <= nxt_src[15:8]; src_lo <= nxt_src[7:0];
          dst_hi <= nxt_dst[15:8]; dst_lo <= nxt_dst[7:0];
          if (hb_mode) begin
            ctl <= ctl_dec;
            if (ctl_dec == 8'hFF) hb_mode <= 1'b0;
          end else begin
            ctl <= 8'hFF;
          end
        end
      end
    end
  end

  // R5
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> mem_wr);

  // R5
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> $past(mem_wr));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mem_rd_addr == $past(mem_rd_addr) + 16'd1 &&
               mem_wr_addr == $past(mem_wr_addr) + 16'd1);

  // R3
  bad_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && src_bad) |=> !cpu_stall);

  // R8
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> $past(hblank_pulse) || $past(reg_wr && reg_sel == 3'd4));

  generate
    if (BYTE_GAP > 1) begin : g_gap
      // R4
      byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr);
    end
  endgenerate
endmodule

// File: tb/vram_copy_dma_tb.sv
module vram_copy_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, lcd_on = 1'b0, hblank_pulse = 1'b0;
  logic [2:0] reg_sel = 3'd0, reg_rd_sel = 3'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata, mem_rdata, mem_wdata;
  logic [1:0] vid_mode = 2'd2;
  logic mem_rd, mem_wr, cpu_stall;
  logic [15:0] mem_rd_addr, mem_wr_addr;

  int checks = 0, errors = 0, wr_count = 0, cyc = 0, last_cyc = 0;
  bit more = 0, drop_pending = 0;
  logic [15:0] q_src[$], q_dst[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction
  assign mem_rdata = pat(mem_rd_addr);

  vram_copy_dma #(.BYTE_GAP(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rd_sel(reg_rd_sel), .reg_rdata(reg_rdata),
    .lcd_on(lcd_on), .vid_mode(vid_mode), .hblank_pulse(hblank_pulse),
    .mem_rd(mem_rd), .mem_rd_addr(mem_rd_addr), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_wr_addr(mem_wr_addr), .mem_wdata(mem_wdata),
    .cpu_stall(cpu_stall));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_burst(input logic [15:0] s, input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      q_src.push_back(s + 16'(i));
      q_dst.push_back(d + 16'(i));
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (drop_pending) begin
      chk(!cpu_stall, "R5 stall falls after last byte", cpu_stall, 0);
      drop_pending = 0;
    end
    if (mem_wr) begin
      wr_count++;
      if (q_src.size() == 0) begin
        chk(0, "R10 unexpected write", mem_wr_addr, 0);
      end else begin
        logic [15:0] es, ed;
        es = q_src.pop_front();
        ed = q_dst.pop_front();
        chk(mem_rd_addr == es && mem_rd, "R2 source address", mem_rd_addr, es);
        chk(mem_wr_addr == ed, "R2 destination address", mem_wr_addr, ed);
        chk(mem_wdata == pat(es), "R4 data", mem_wdata, pat(es));
        chk(cpu_stall, "R5 stall during byte", cpu_stall, 1);
        if (more) chk(cyc - last_cyc == GAP, "R4 byte pacing", cyc - last_cyc, GAP);
        last_cyc = cyc;
        more = q_src.size() != 0;
        if (!more) drop_pending = 1;
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    hblank_pulse = 1'b1;
    @(negedge clk);
    hblank_pulse = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_rd_sel = sel;
    #1;
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (cpu_stall || q_src.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic set_addr(input logic [15:0] s, input logic [15:0] d);
    wr(3'd0, s[15:8]); wr(3'd1, s[7:0]);
    wr(3'd2, d[15:8]); wr(3'd3, d[7:0]);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd0, 8'h00, "R1 source high");
    rd(3'd1, 8'h00, "R1 source low");
    rd(3'd2, 8'h00, "R1 dest high");
    rd(3'd3, 8'h00, "R1 dest low");
    rd(3'd4, 8'hFF, "R1 control");
    chk(!cpu_stall && wr_count == 0, "R1 idle", cpu_stall, 0);

    // R4 R2 R6 bulk copy of 3 blocks
    set_addr(16'h1234, 16'hE567);
    base = wr_count;
    expect_burst(16'h1230, 16'h8560, 48);
    wr(3'd4, 8'h02);
    wait_idle();
    chk(wr_count - base == 48, "R4 bulk length", wr_count - base, 48);
    rd(3'd0, 8'h12, "R6 source high");
    rd(3'd1, 8'h60, "R6 source low");
    rd(3'd2, 8'h85, "R6 dest high");
    rd(3'd3, 8'h90, "R6 dest low");
    rd(3'd4, 8'hFF, "R6 control after bulk");

    // R3 rejected source
    wr(3'd0, 8'h8A);
    base = wr_count;
    wr(3'd4, 8'h05);
    repeat (30) @(negedge clk);
    chk(wr_count == base && !cpu_stall, "R3 nothing moved", wr_count - base, 0);
    rd(3'd4, 8'h85, "R3 control");
    rd(3'd0, 8'h8A, "R3 source kept");

    // R8 armed paced mode
    lcd_on = 1'b1; vid_mode = 2'd2;
    set_addr(16'hC000, 16'h0010);
    base = wr_count;
    wr(3'd4, 8'h81);
    repeat (10) @(negedge clk);
    chk(wr_count == base, "R8 no copy when armed", wr_count - base, 0);
    rd(3'd4, 8'h01, "R8 control armed");
    expect_burst(16'hC000, 16'h8010, 16);
    pulse();
    wait_idle();
    chk(wr_count - base == 16, "R8 one slice", wr_count - base, 16);
    rd(3'd4, 8'h00, "R8 control after first slice");
    rd(3'd1, 8'h10, "R6 source low after slice");
    expect_burst(16'hC010, 16'h8020, 16);
    pulse();
    wait_idle();
    rd(3'd4, 8'hFF, "R8 control wraps");
    base = wr_count;
    pulse();
    repeat (10) @(negedge clk);
    chk(wr_count == base, "R8 R10 pulse after end ignored", wr_count - base, 0);

    // R7 immediate slice, R10 writes and pulses ignored while busy
    vid_mode = 2'd0;
    set_addr(16'h4000, 16'h0100);
    base = wr_count;
    expect_burst(16'h4000, 16'h8100, 16);
    wr(3'd4, 8'h82);
    wr(3'd4, 8'h7F);
    pulse();
    wait_idle();
    chk(wr_count - base == 16, "R7 R10 exactly one slice", wr_count - base, 16);
    rd(3'd4, 8'h01, "R7 R10 control after slice");

    // R11 cancel paced mode
    vid_mode = 2'd2;
    base = wr_count;
    wr(3'd4, 8'h03);
    pulse();
    repeat (10) @(negedge clk);
    chk(wr_count == base, "R11 no copy after cancel", wr_count - base, 0);
    rd(3'd4, 8'h03, "R11 control");

    // R9 paced request with LCD off
    lcd_on = 1'b0;
    wr(3'd4, 8'h85);
    pulse();
    repeat (10) @(negedge clk);
    chk(wr_count == base, "R9 no copy with LCD off", wr_count - base, 0);
    rd(3'd4, 8'h86, "R9 control");
    lcd_on = 1'b1;
    expect_burst(16'h4010, 16'h8110, 16);
    pulse();
    wait_idle();
    chk(wr_count - base == 16, "R9 slice after LCD on", wr_count - base, 16);
    rd(3'd4, 8'h85, "R9 control after slice");
    lcd_on = 1'b0;
    wr(3'd4, 8'h00);

    // R4 longest bulk copy
    set_addr(16'h00F0, 16'h1F00);
    base = wr_count;
    expect_burst(16'h00F0, 16'h9F00, 2048);
    wr(3'd4, 8'h7F);
    wait_idle();
    chk(wr_count - base == 2048, "R4 longest bulk", wr_count - base, 2048);
    rd(3'd2, 8'hA7, "R6 dest high after long copy");
    rd(3'd0, 8'h08, "R6 source high after long copy");
    rd(3'd4, 8'hFF, "R6 control after long copy");

    summary();
    $finish;
  end
endmodule